// File: doc/BRIEF.md
# Evaluation Stack State Saver

This block moves the contents of a register-file evaluation stack, together with its stack pointer and a pending break byte, out to a state vector in word-addressed memory, and brings them back again. A single start pulse launches the operation, and a mode bit chooses its direction. The caller supplies the base address of the vector. The block drives the stack register file through one read/write index port and drives memory through one single-word port. Memory reads return data one cycle after the request.

A save first checks the stack pointer. It then copies the live entries plus the two entries just above the top of stack into the start of the vector. After that it writes one status word that combines the break byte and the pointer. Finally it sets both the stack pointer and the break byte to zero. A load reads the status word first. It takes the break byte and the pointer from that word, then refills the stack from the vector, again including the two entries above the top. Both directions refuse a pointer larger than the stack depth: they raise an error and change nothing.

Top module: `stack_state_saver`

## Requirements
- R1: A save started with a stack pointer greater than DEPTH ends with `err` high during the `done` pulse. It writes no memory and leaves the stack, the pointer and the break byte unchanged.
- R2: A save with a valid pointer SP writes stack entry k+1 to memory word base+k for every k from 0 up to SP+1, so two entries above the top are always kept.
- R3: A save writes the status word to base+DEPTH after all stack words, so the status word wins wherever the two overlap. Bits 15:8 of the status word hold the break byte and bits 7:0 hold the stack pointer. A save writes no other memory word.
- R4: A successful save loads 0 into both the stack pointer and the break byte, and leaves every stack entry unchanged.
- R5: A load reads the status word at base+DEPTH before any other word. It sets the break byte from bits 15:8 of that word and the stack pointer from bits 7:0.
- R6: A load with status pointer SP fills stack entry k+1 with memory word base+k for k from 0 up to SP+1. Entry 0 and the entries above SP+2 are left unchanged.
- R7: A load whose status pointer is greater than DEPTH ends with `err` high during `done`. It leaves the stack, the pointer, the break byte and memory unchanged.
- R8: `done` is a single-cycle pulse and `busy` is high from the cycle after the start until `done`. A start seen while `busy` is high is ignored.
- R9: After reset the block is idle, with `busy`, `done`, `err` and every write and request strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode | input | 1 | 0 selects save, 1 selects load |
| base | input | AW | Word address of the state vector |
| sp_in | input | W/2 | Current stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | W/2 | New stack pointer value |
| brk_in | input | W/2 | Current break byte |
| brk_we | output | 1 | Break byte write strobe |
| brk_out | output | W/2 | New break byte value |
| stk_idx | output | clog2(DEPTH+3) | Stack entry index for read and write |
| stk_rdata | input | W | Stack entry at `stk_idx` (combinational read) |
| stk_we | output | 1 | Stack entry write strobe |
| stk_wdata | output | W | Stack entry write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected stack pointer, valid while `done` is high |

## Verification
The bench builds the block with DEPTH=6 and an 8-bit address. At that size it can sweep every stack pointer from 0 to DEPTH+2, plus a pointer far out of range, in both directions and at two different bases. The small depth means the trailing stack words reach the status slot and one word past it. This exercises the overlap rule and the one-word clobber past the status slot. The expected memory image and the expected register-file image are computed arithmetically for every pointer value and compared word by word.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SV_WR,
        S_SV_ST,
        S_LD_ST,
        S_LD_UNPK,
        S_LD_RQ,
        S_LD_WR,
        S_DONE
    } ssv_state_e;

    localparam logic OP_SAVE = 1'b0;
    localparam logic OP_LOAD = 1'b1;

endpackage

// File: rtl/ssv_sp_check.sv
module ssv_sp_check #(
    parameter int DEPTH = 14,
    parameter int HW    = 8
) (
    input  logic [HW-1:0] sp,
    output logic          ok
);
    // A pointer is usable only up to DEPTH; DEPTH+2 entries must stay addressable
    localparam logic [HW-1:0] SP_MAX = HW'(DEPTH);

    always_comb begin
        ok = (sp <= SP_MAX);
    end
endmodule

// File: rtl/ssv_status_codec.sv
module ssv_status_codec #(
    parameter int W = 16
) (
    input  logic [W/2-1:0] pk_brk,
    input  logic [W/2-1:0] pk_sp,
    output logic [W-1:0]   pk_word,
    input  logic [W-1:0]   up_word,
    output logic [W/2-1:0] up_brk,
    output logic [W/2-1:0] up_sp
);
    localparam int HW = W / 2;

    always_comb begin
        pk_word = {pk_brk, pk_sp};
        up_brk  = up_word[W-1:HW];
        up_sp   = up_word[HW-1:0];
    end
endmodule

// File: rtl/ssv_addr.sv
module ssv_addr #(
    parameter int AW = 16,
    parameter int OW = 5
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    output logic [AW-1:0] addr
);
    always_comb begin
        addr = base + AW'(off);
    end
endmodule

// File: rtl/stack_state_saver.sv
module stack_state_saver
    import ssv_pkg::*;
#(
    parameter int DEPTH = 14,
    parameter int W     = 16,
    parameter int AW    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         mode,
    input  logic [AW-1:0]                base,
    input  logic [W/2-1:0]               sp_in,
    output logic                         sp_we,
    output logic [W/2-1:0]               sp_out,
    input  logic [W/2-1:0]               brk_in,
    output logic                         brk_we,
    output logic [W/2-1:0]               brk_out,
    output logic [$clog2(DEPTH+3)-1:0]   stk_idx,
    input  logic [W-1:0]                 stk_rdata,
    output logic                         stk_we,
    output logic [W-1:0]                 stk_wdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [W-1:0]                 mem_wdata,
    input  logic [W-1:0]                 mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         err
);
    localparam int HW = W / 2;
    localparam int IW = $clog2(DEPTH + 3);
    localparam logic [IW-1:0] STAT_OFF = IW'(DEPTH);

    typedef struct packed {
        ssv_state_e    st;
        logic          mode;
        logic [IW-1:0] cnt;
        logic [HW-1:0] sp;
        logic [HW-1:0] brk;
        logic [AW-1:0] base;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          sv_ok;
    logic          ld_ok;
    logic [W-1:0]  stat_word;
    logic [HW-1:0] ld_brk;
    logic [HW-1:0] ld_sp;
    logic [IW-1:0] mem_off;
    logic          last_word;

    ssv_sp_check #(.DEPTH(DEPTH), .HW(HW)) u_sv_chk (
        .sp (sp_in),
        .ok (sv_ok)
    );

    ssv_sp_check #(.DEPTH(DEPTH), .HW(HW)) u_ld_chk (
        .sp (ld_sp),
        .ok (ld_ok)
    );

    ssv_status_codec #(.W(W)) u_codec (
        .pk_brk  (ctl_q.brk),
        .pk_sp   (ctl_q.sp),
        .pk_word (stat_word),
        .up_word (mem_rdata),
        .up_brk  (ld_brk),
        .up_sp   (ld_sp)
    );

    ssv_addr #(.AW(AW), .OW(IW)) u_addr (
        .base (ctl_q.base),
        .off  (mem_off),
        .addr (mem_addr)
    );

    // Transfer covers vector words 0 .. SP+1
    always_comb begin
        last_word = (HW'(ctl_q.cnt) == ctl_q.sp + HW'(1));
    end

    always_comb begin
        ctl_d     = ctl_q;
        stk_idx   = '0;
        stk_we    = 1'b0;
        stk_wdata = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_off   = '0;
        mem_wdata = '0;
        sp_we     = 1'b0;
        sp_out    = '0;
        brk_we    = 1'b0;
        brk_out   = '0;

        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.base = base;
                    ctl_d.mode = mode;
                    ctl_d.err  = 1'b0;
                    ctl_d.cnt  = '0;
                    if (mode == OP_LOAD) begin
                        ctl_d.st = S_LD_ST;
                    end else if (!sv_ok) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = S_DONE;
                    end else begin
                        ctl_d.sp  = sp_in;
                        ctl_d.brk = brk_in;
                        ctl_d.st  = S_SV_WR;
                    end
                end
            end

            S_SV_WR: begin
                stk_idx   = ctl_q.cnt + IW'(1);
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_off   = ctl_q.cnt;
                mem_wdata = stk_rdata;
                ctl_d.cnt = ctl_q.cnt + IW'(1);
                if (last_word) begin
                    ctl_d.st = S_SV_ST;
                end
            end

            S_SV_ST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_off   = STAT_OFF;
                mem_wdata = stat_word;
                sp_we     = 1'b1;
                sp_out    = '0;
                brk_we    = 1'b1;
                brk_out   = '0;
                ctl_d.st  = S_DONE;
            end

            S_LD_ST: begin
                mem_req  = 1'b1;
                mem_off  = STAT_OFF;
                ctl_d.st = S_LD_UNPK;
            end

            S_LD_UNPK: begin
                if (!ld_ok) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = S_DONE;
                end else begin
                    brk_we    = 1'b1;
                    brk_out   = ld_brk;
                    sp_we     = 1'b1;
                    sp_out    = ld_sp;
                    ctl_d.sp  = ld_sp;
                    ctl_d.brk = ld_brk;
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_LD_RQ;
                end
            end

            S_LD_RQ: begin
                mem_req  = 1'b1;
                mem_off  = ctl_q.cnt;
                ctl_d.st = S_LD_WR;
            end

            S_LD_WR: begin
                stk_idx   = ctl_q.cnt + IW'(1);
                stk_we    = 1'b1;
                stk_wdata = mem_rdata;
                ctl_d.cnt = ctl_q.cnt + IW'(1);
                ctl_d.st  = last_word ? S_DONE : S_LD_RQ;
            end

            S_DONE: begin
                ctl_d.st = S_IDLE;
            end

            default: begin
                ctl_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, mode: 1'b0, cnt: '0, sp: '0, brk: '0, base: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        busy = (ctl_q.st != S_IDLE);
        done = (ctl_q.st == S_DONE);
        err  = done & ctl_q.err;
    end

    // R1: an out-of-range save pointer is answered by an error completion
    a_r1_reject_save: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE && start && mode == OP_SAVE && sp_in > HW'(DEPTH)) |=> (done && err));

    // R3: pointer/break clearing on save coincides with the status write
    a_r3_status_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && ctl_q.mode == OP_SAVE) |->
            (mem_req && mem_we && mem_addr == ctl_q.base + AW'(DEPTH)
             && mem_wdata[HW-1:0] == ctl_q.sp));

    // R6: restored entries never touch entry 0 or go past DEPTH+2
    a_r6_entry_range: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> (stk_idx != '0 && stk_idx <= IW'(DEPTH + 2)));

    // R7: an error completion follows a cycle with no register-file update
    a_r7_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!$past(sp_we) && !$past(brk_we) && !$past(stk_we)));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing is driven while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || stk_we || sp_we || brk_we));

endmodule

// File: tb/tb_stack_state_saver.sv
`timescale 1ns/1ps
module tb_stack_state_saver;
    localparam int D  = 6;
    localparam int W  = 16;
    localparam int AW = 8;
    localparam int HW = W / 2;
    localparam int IW = $clog2(D + 3);
    localparam int NE = D + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] base = '0;
    logic [HW-1:0] sp_reg = '0;
    logic [HW-1:0] brk_reg = '0;
    logic          sp_we, brk_we, stk_we, mem_req, mem_we, busy, done, err;
    logic [HW-1:0] sp_out, brk_out;
    logic [IW-1:0] stk_idx;
    logic [W-1:0]  stk_rdata, stk_wdata, mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    logic [W-1:0]  stk  [NE];
    logic [W-1:0]  mem  [256];
    logic [W-1:0]  expm [256];
    logic [W-1:0]  exps [NE];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stack_state_saver #(.DEPTH(D), .W(W), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .sp_in(sp_reg), .sp_we(sp_we), .sp_out(sp_out),
        .brk_in(brk_reg), .brk_we(brk_we), .brk_out(brk_out),
        .stk_idx(stk_idx), .stk_rdata(stk_rdata), .stk_we(stk_we), .stk_wdata(stk_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err(err)
    );

    assign stk_rdata = (int'(stk_idx) < NE) ? stk[stk_idx] : '0;

    always @(posedge clk) begin
        if (stk_we && int'(stk_idx) < NE) stk[stk_idx] <= stk_wdata;
        if (sp_we)  sp_reg  <= sp_out;
        if (brk_we) brk_reg <= brk_out;
        if (mem_req && mem_we)  mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Launch one operation; optionally pulse a stray start while busy.
    task automatic run_op(input logic m, input logic [AW-1:0] b, input bit stray, output bit e);
        int n = 0;
        @(negedge clk);
        start = 1'b1; mode = m; base = b;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            @(negedge clk);
            chk(busy == 1'b1, "R8 busy during op", busy, 1);
            start = 1'b1; mode = ~m; base = b + AW'(3);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        e = err;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 done single pulse", {busy, done}, 0);
    endtask

    task automatic save_case(input int s, input logic [AW-1:0] b, input bit stray);
        bit e;
        bit valid = (s <= D);
        logic [HW-1:0] b0 = HW'(8'h30 + s);
        for (int i = 0; i < 256; i++) mem[i] = W'(16'hEE00 + i);
        for (int k = 0; k < NE; k++) stk[k] = W'(16'h1000 * (s % 8) + 16'h0101 * k + 16'h0007);
        sp_reg = HW'(s); brk_reg = b0;
        for (int i = 0; i < 256; i++) expm[i] = mem[i];
        for (int k = 0; k < NE; k++) exps[k] = stk[k];
        if (valid) begin
            for (int i = 0; i <= s + 1; i++) expm[int'(b) + i] = stk[i + 1];
            expm[int'(b) + D] = {b0, HW'(s)};
        end
        run_op(1'b0, b, stray, e);
        if (valid) chk(e == 1'b0, $sformatf("R2 save sp=%0d no error", s), e, 0);
        else       chk(e == 1'b1, $sformatf("R1 save sp=%0d rejected", s), e, 1);
        for (int i = int'(b) - 2; i < int'(b) + D + 5; i++) begin
            if (i == int'(b) + D)
                chk(mem[i] == expm[i], $sformatf("R3 status word sp=%0d", s), mem[i], expm[i]);
            else
                chk(mem[i] == expm[i], $sformatf("R2 vector word %0d sp=%0d", i - int'(b), s), mem[i], expm[i]);
        end
        for (int k = 0; k < NE; k++)
            chk(stk[k] == exps[k], $sformatf("R4 stack entry %0d kept sp=%0d", k, s), stk[k], exps[k]);
        if (valid) begin
            chk(sp_reg == '0, "R4 sp cleared", sp_reg, 0);
            chk(brk_reg == '0, "R4 break cleared", brk_reg, 0);
        end else begin
            chk(sp_reg == HW'(s), "R1 sp kept", sp_reg, s);
            chk(brk_reg == b0, "R1 break kept", brk_reg, b0);
        end
    endtask

    task automatic load_case(input int s, input logic [AW-1:0] b);
        bit e;
        bit valid = (s <= D);
        logic [HW-1:0] bb = HW'(8'h90 + 3 * s);
        logic [HW-1:0] sp0 = HW'(8'hA5);
        logic [HW-1:0] brk0 = HW'(8'h5A);
        for (int i = 0; i < 256; i++) mem[i] = W'(16'h5000 + 3 * i + s);
        mem[int'(b) + D] = {bb, HW'(s)};
        for (int k = 0; k < NE; k++) stk[k] = W'(16'hC000 + k);
        sp_reg = sp0; brk_reg = brk0;
        for (int i = 0; i < 256; i++) expm[i] = mem[i];
        for (int k = 0; k < NE; k++) exps[k] = stk[k];
        if (valid) for (int k = 1; k <= s + 2; k++) exps[k] = mem[int'(b) + k - 1];
        run_op(1'b1, b, 1'b0, e);
        if (valid) begin
            chk(e == 1'b0, $sformatf("R5 load sp=%0d no error", s), e, 0);
            chk(sp_reg == HW'(s), "R5 sp from low byte", sp_reg, s);
            chk(brk_reg == bb, "R5 break from high byte", brk_reg, bb);
        end else begin
            chk(e == 1'b1, $sformatf("R7 load sp=%0d rejected", s), e, 1);
            chk(sp_reg == sp0, "R7 sp kept", sp_reg, sp0);
            chk(brk_reg == brk0, "R7 break kept", brk_reg, brk0);
        end
        for (int k = 0; k < NE; k++)
            chk(stk[k] == exps[k], $sformatf("R6 entry %0d after load sp=%0d", k, s), stk[k], exps[k]);
        for (int i = int'(b) - 1; i < int'(b) + D + 3; i++)
            chk(mem[i] == expm[i], "R7 memory untouched by load", mem[i], expm[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R9 reset outputs", {busy, done, err}, 0);
        chk(!mem_req && !stk_we && !sp_we && !brk_we, "R9 reset strobes",
            {mem_req, stk_we, sp_we, brk_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after reset", busy, 0);

        for (int s = 0; s <= D + 2; s++) begin
            save_case(s, AW'(8), 1'b0);
            save_case(s, AW'(100), 1'b0);
        end
        save_case(255, AW'(40), 1'b0);
        save_case(2, AW'(60), 1'b1);   // R8 stray start while busy
        save_case(D, AW'(60), 1'b1);

        for (int s = 0; s <= D + 2; s++) begin
            load_case(s, AW'(8));
            load_case(s, AW'(120));
        end
        load_case(200, AW'(30));

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule